// File: doc/BRIEF.md
# Bitstream Header Clock-Ratio Selector

This block watches a configuration image as it streams in, one 32-bit word on each beat where the valid input is high. It picks out two header words. One carries an encryption field and the other carries a compression bit. From these it works out the clock-to-data ratio code, and it reports the width select for a passive-parallel configuration port. The result is ready as soon as the compression word has passed. The payload itself goes by without being looked at.

A start pulse on the first word opens an image. The same beat latches the image length in words and the port width. Full configuration uses the 32-bit width and partial reconfiguration uses the 16-bit width. If the image is too short to hold the compression word, the error flag is raised when the image ends, and no ratio is produced.

Top module: `cfg_ratio_sel`

## Requirements
- R1: While reset is high and in the cycle after it, `ratio_code`, `port_wide`, `hdr_done` and `short_err` are all 0.
- R2: The image counts as encrypted when bits [3:2] of word index 69 hold any nonzero value (1, 2 or 3). All other bits and words have no effect on this decision.
- R3: The image counts as compressed when bit 1 of word index 229 is 0. A 1 in that bit means it is not compressed.
- R4: Ratio codes are x1=0, x2=1, x4=2, x8=3. With a 16-bit port, a compressed image gives 2, an image that is encrypted but not compressed gives 1, and a plain image gives 0.
- R5: With a 32-bit port (`wide_port`=1 at the start beat), the code chosen under R4 is incremented by one.
- R6: `hdr_done` is high for exactly one cycle: the cycle after the beat that carries word 229. `ratio_code` takes its new value in that same cycle.
- R7: An image whose length is below 230 words never raises `hdr_done`, and its `ratio_code` stays 0. `short_err` rises in the cycle after the image's last word (index length-1, or the start beat when the length is 0 or 1), and it stays high until the next start beat. A length of exactly 230 is accepted.
- R8: A beat is a cycle with `word_valid`=1. The start beat has `img_start`=1 together with `word_valid`=1 and is word index 0. Cycles with `word_valid`=0 do not advance the index. `img_start` without `word_valid` is ignored.
- R9: `ratio_code` holds from the done pulse until the next start beat. That start beat clears `ratio_code` and `short_err` to 0. Words after index 229, and valid beats after the image has ended, change nothing.
- R10: `port_wide` shows the `wide_port` value sampled at the latest start beat. The length is also sampled only then. Later changes on either input have no effect on the current image.
- R11: A start beat in the middle of an image drops that image and begins a new one at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_start | input | 1 | Marks the first word of an image; qualified by `word_valid` |
| word_valid | input | 1 | Beat qualifier for `word_data` |
| word_data | input | 32 | Image word |
| img_words | input | LEN_W (16) | Image length in words, sampled at the start beat |
| wide_port | input | 1 | 1 = 32-bit port, 0 = 16-bit port, sampled at the start beat |
| ratio_code | output | 2 | Clock-to-data ratio code (0=x1, 1=x2, 2=x4, 3=x8) |
| port_wide | output | 1 | Width select latched at the start beat |
| hdr_done | output | 1 | One-cycle pulse when the ratio is valid |
| short_err | output | 1 | Image shorter than 230 words; held until next start |

## Verification
Some properties are checked on every cycle. The done pulse never lasts more than one cycle, and it never appears together with the error flag. A rejected image keeps the ratio at x1. The ratio only moves at a done pulse or a start beat. A 16-bit port never reports x8. The word index holds through idle cycles. Some behaviour can only be shown by the bench scenarios, which replay images against a beat-level model: the exact code for each combination of flags and width, the 229/230 length boundary, gaps in the stream, a start asserted without valid, a restart in mid-image, and the latching of width and length at the start beat.

// File: rtl/cfg_ratio_pkg.sv
package cfg_ratio_pkg;

  typedef logic [1:0] ratio_t;

  localparam ratio_t RATIO_X1 = 2'd0;
  localparam ratio_t RATIO_X2 = 2'd1;
  localparam ratio_t RATIO_X4 = 2'd2;
  localparam ratio_t RATIO_X8 = 2'd3;

  // Base code from the flags; a wide port steps the code up by one.
  function automatic ratio_t pick_ratio(input logic encrypted,
                                        input logic not_compressed,
                                        input logic wide);
    ratio_t base;
    if (!not_compressed)
      base = RATIO_X4;
    else if (encrypted)
      base = RATIO_X2;
    else
      base = RATIO_X1;
    return wide ? ratio_t'(base + 2'd1) : base;
  endfunction

endpackage

// File: rtl/cfg_beat_counter.sv
module cfg_beat_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             sop,
  input  logic [LEN_W-1:0] len,
  output logic             beat_start,
  output logic             beat_ok,
  output logic [LEN_W-1:0] beat_idx,
  output logic             beat_last
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             active_q;
  logic [LEN_W-1:0] len_eff;

  assign beat_start = valid & sop;
  assign beat_ok    = beat_start | (valid & active_q);
  assign beat_idx   = beat_start ? '0 : cnt_q;
  assign len_eff    = beat_start ? len : len_q;
  assign beat_last  = ({1'b0, beat_idx} + (LEN_W+1)'(1)) >= {1'b0, len_eff};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      len_q    <= '0;
      active_q <= 1'b0;
    end else if (beat_ok) begin
      cnt_q    <= beat_idx + LEN_W'(1);
      active_q <= !beat_last;
      if (beat_start) len_q <= len;
    end
  end

  // R8: idle cycles never move the word index
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(cnt_q));

  // R8: a running image never has an index beyond its length
  assert_idx_in_len_R8: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < len_q));

endmodule

// File: rtl/cfg_hdr_decide.sv
module cfg_hdr_decide
  import cfg_ratio_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_start,
  input  logic             beat_ok,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic             beat_last,
  input  logic [1:0]       enc_field,
  input  logic             cmp_bit,
  input  logic             wide,
  output ratio_t           ratio_q,
  output logic             done_q,
  output logic             err_q
);

  localparam logic [IDX_W-1:0] ENC_POS = IDX_W'(ENC_IDX);
  localparam logic [IDX_W-1:0] CMP_POS = IDX_W'(CMP_IDX);

  logic enc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_q   <= 1'b0;
      ratio_q <= RATIO_X1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (beat_start) begin
        enc_q   <= 1'b0;
        ratio_q <= RATIO_X1;
        err_q   <= 1'b0;
      end
      if (beat_ok) begin
        if (beat_idx == ENC_POS)
          enc_q <= |enc_field;
        if (beat_idx == CMP_POS) begin
          ratio_q <= pick_ratio(enc_q, cmp_bit, wide);
          done_q  <= 1'b1;
        end
        if (beat_last && (beat_idx < CMP_POS))
          err_q <= 1'b1;
      end
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done_q && err_q));

  assert_err_no_ratio_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (ratio_q == RATIO_X1));

endmodule

// File: rtl/cfg_ratio_sel.sv
module cfg_ratio_sel
  import cfg_ratio_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             img_start,
  input  logic             word_valid,
  input  logic [31:0]      word_data,
  input  logic [LEN_W-1:0] img_words,
  input  logic             wide_port,
  output logic [1:0]       ratio_code,
  output logic             port_wide,
  output logic             hdr_done,
  output logic             short_err
);

  logic             beat_start;
  logic             beat_ok;
  logic [LEN_W-1:0] beat_idx;
  logic             beat_last;
  logic             wide_q;
  ratio_t           ratio_w;

  cfg_beat_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .valid      (word_valid),
    .sop        (img_start),
    .len        (img_words),
    .beat_start (beat_start),
    .beat_ok    (beat_ok),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst)             wide_q <= 1'b0;
    else if (beat_start) wide_q <= wide_port;
  end

  cfg_hdr_decide #(
    .IDX_W   (LEN_W),
    .ENC_IDX (ENC_IDX),
    .CMP_IDX (CMP_IDX)
  ) u_dec (
    .clk        (clk),
    .rst        (rst),
    .beat_start (beat_start),
    .beat_ok    (beat_ok),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last),
    .enc_field  (word_data[ENC_LSB +: 2]),
    .cmp_bit    (word_data[CMP_BIT]),
    .wide       (wide_q),
    .ratio_q    (ratio_w),
    .done_q     (hdr_done),
    .err_q      (short_err)
  );

  assign ratio_code = ratio_w;
  assign port_wide  = wide_q;

  assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && img_start) |=> (hdr_done || $stable(ratio_code)));

  assert_narrow_no_x8_R4: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && !port_wide) |-> (ratio_code != RATIO_X8));

  assert_width_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && img_start) |=> $stable(port_wide));

endmodule

// File: tb/sim_cfg_ratio_sel.sv
module sim_cfg_ratio_sel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        img_start = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic [15:0] img_words = '0;
  logic        wide_port = 1'b0;
  logic [1:0]  ratio_code;
  logic        port_wide;
  logic        hdr_done;
  logic        short_err;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural model state
  int   m_next = 0;
  int   m_len = 0;
  bit   m_active = 0;
  bit   m_enc = 0;
  bit   m_wide = 0;
  int   m_ratio = 0;
  bit   m_done = 0;
  bit   m_err = 0;

  always #2 clk = ~clk;

  cfg_ratio_sel u0 (
    .clk        (clk),
    .rst        (rst),
    .img_start  (img_start),
    .word_valid (word_valid),
    .word_data  (word_data),
    .img_words  (img_words),
    .wide_port  (wide_port),
    .ratio_code (ratio_code),
    .port_wide  (port_wide),
    .hdr_done   (hdr_done),
    .short_err  (short_err)
  );

  task automatic model_beat(input int i, input logic [31:0] d);
    if (i == 69) m_enc = (d[3:2] != 2'b00);
    if (i == 229) begin
      if (d[1] == 1'b0)  m_ratio = 2;
      else if (m_enc)    m_ratio = 1;
      else               m_ratio = 0;
      if (m_wide) m_ratio = m_ratio + 1;
      m_done = 1;
    end
    if (i + 1 >= m_len) begin
      m_active = 0;
      if (i < 229) m_err = 1;
    end
    m_next = i + 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_next = 0; m_len = 0; m_active = 0; m_enc = 0;
      m_wide = 0; m_ratio = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (word_valid && img_start) begin
        m_len = int'(img_words); m_wide = wide_port;
        m_ratio = 0; m_err = 0; m_enc = 0; m_active = 1;
        model_beat(0, word_data);
      end else if (word_valid && m_active) begin
        model_beat(m_next, word_data);
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (ratio_code !== 2'(m_ratio) || hdr_done !== m_done ||
        short_err !== m_err || port_wide !== m_wide) begin
      errors++;
      $display("FAIL %s cycle %0d: ratio/done/err/wide = %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
               cur_req, cycles, ratio_code, hdr_done, short_err, port_wide,
               m_ratio, m_done, m_err, m_wide);
    end
    if (hdr_done === 1'b1) done_seen++;
  end

  task automatic finish_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
      finish_all();
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [1:0] encf, input logic cbit, input logic w);
    int r;
    if (cbit == 1'b0)       r = 2;
    else if (encf != 2'b00) r = 1;
    else                    r = 0;
    return w ? r + 1 : r;
  endfunction

  function automatic logic [31:0] img_word(input int i, input logic [1:0] encf, input logic cbit);
    logic [31:0] w;
    w = 32'hA5C3_0F96 ^ (32'(i) * 32'h0101_0101);
    if (i == 69)  w[3:2] = encf;
    if (i == 229) w[1] = cbit;
    return w;
  endfunction

  // Send nsent words of an image declared as len words long.
  task automatic send_image(input int len, input int nsent, input logic [1:0] encf,
                            input logic cbit, input logic w, input int gap);
    for (int i = 0; i < nsent; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        word_valid = 1'b0; img_start = 1'b1;
        word_data = img_word(229, 2'b00, 1'b0);
        @(negedge clk);
      end
      word_valid = 1'b1;
      img_start  = (i == 0);
      word_data  = img_word(i, encf, cbit);
      if (i == 0) begin
        img_words = 16'(len); wide_port = w;
      end else begin
        img_words = 16'd5; wide_port = ~w;
      end
      @(negedge clk);
    end
    word_valid = 1'b0; img_start = 1'b0;
  endtask

  task automatic run_case(input string req, input int len, input logic [1:0] encf,
                          input logic cbit, input logic w, input int gap);
    int exp_done;
    cur_req = req;
    done_seen = 0;
    send_image(len, len, encf, cbit, w, gap);
    repeat (3) @(negedge clk);
    exp_done = (len >= 230) ? 1 : 0;
    check(req, done_seen, exp_done, "done pulses");
    check(req, int'(ratio_code), exp_done ? exp_ratio(encf, cbit, w) : 0, "ratio_code");
    check(req, int'(short_err), exp_done ? 0 : 1, "short_err");
    check("R10", int'(port_wide), int'(w), "port_wide latched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(ratio_code), 0, "reset ratio");
    check("R1", int'({hdr_done, short_err, port_wide}), 0, "reset flags");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'({ratio_code, hdr_done, short_err, port_wide}), 0, "after reset");

    run_case("R4", 240, 2'b00, 1'b1, 1'b0, 0);
    run_case("R4", 240, 2'b00, 1'b0, 1'b0, 0);
    run_case("R2", 240, 2'b10, 1'b1, 1'b0, 0);
    run_case("R3", 250, 2'b11, 1'b0, 1'b0, 0);
    run_case("R5", 240, 2'b00, 1'b1, 1'b1, 0);
    run_case("R5", 240, 2'b01, 1'b1, 1'b1, 0);
    run_case("R5", 235, 2'b11, 1'b0, 1'b1, 0);
    run_case("R2", 240, 2'b01, 1'b1, 1'b0, 0);
    run_case("R8", 240, 2'b01, 1'b1, 1'b0, 7);
    run_case("R8", 230, 2'b00, 1'b0, 1'b1, 3);
    run_case("R7", 100, 2'b11, 1'b0, 1'b1, 0);
    run_case("R7", 229, 2'b01, 1'b0, 1'b0, 0);
    run_case("R7", 230, 2'b01, 1'b1, 1'b0, 0);
    run_case("R7", 1, 2'b00, 1'b1, 1'b0, 0);

    // R9: longer image, then stray beats after the end
    run_case("R9", 400, 2'b10, 1'b1, 1'b1, 0);
    cur_req = "R9";
    for (int k = 0; k < 240; k++) begin
      word_valid = 1'b1; img_start = 1'b0; word_data = 32'h0000_0000;
      @(negedge clk);
    end
    word_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", int'(ratio_code), exp_ratio(2'b10, 1'b1, 1'b1), "ratio held after stray beats");

    // R11: restart mid-image
    cur_req = "R11";
    done_seen = 0;
    send_image(300, 150, 2'b11, 1'b0, 1'b0, 0);
    @(negedge clk);
    check("R9", int'(ratio_code), 0, "start clears ratio");
    run_case("R11", 260, 2'b00, 1'b1, 1'b1, 0);

    // R9: start clears a held error
    run_case("R7", 50, 2'b00, 1'b1, 1'b0, 0);
    cur_req = "R9";
    word_valid = 1'b1; img_start = 1'b1; img_words = 16'd300;
    word_data = 32'h0; wide_port = 1'b0;
    @(negedge clk);
    word_valid = 1'b0; img_start = 1'b0;
    check("R9", int'(short_err), 0, "start clears err");

    repeat (4) @(negedge clk);
    finish_all();
  end

endmodule